// File: doc/BRIEF.md
# Four-Stage Integer Pipeline with Hazard Resolution

This block is a small in-order integer datapath built as four stages: fetch, operand read, execute and write-back. Every clock it fetches one 32-bit instruction word from an external instruction ROM and moves each instruction one stage down the pipe. The instruction set holds only arithmetic and logic operations. Each operation takes either two register sources or one register and a sign-extended 16-bit constant, and writes one destination register in a 32-entry, 32-bit register file.

When an instruction reads a register that one of the two instructions ahead of it has not yet written back, the block resolves the conflict in one of two ways. The `stall_mode` input selects which. In stall mode the fetch and operand-read stages freeze and empty slots enter the execute stage until the producer has left write-back. In bypass mode, results are forwarded from the execute and write-back stages straight to the operand inputs, and no cycle is lost. A registered debug port reads any register file entry.

The instruction word is laid out as follows. Bit 31 selects constant form (1) or register form (0). Bits 30:29 hold the operation. Bits 28:26 are ignored. Bits 25:21 hold the destination. Bits 20:16 hold source A. Bits 15:11 hold source B in register form. Bits 15:0 hold the constant in constant form.

Top module: `quad_stage_pipe`

## Requirements
- R1: While reset is high and on the first cycle after it, `imem_addr` is 0. With no stall, `imem_addr` rises by one every cycle.
- R2: Operation code 0 adds, 1 subtracts (A minus B), 2 XORs and 3 writes 1 if A is less than or equal to B as signed values, otherwise 0. In constant form the 16-bit constant is sign-extended and replaces B.
- R3: Register 31 always reads as zero on both the operand and the debug paths. A write to it is discarded, and it never causes a stall or a forward.
- R4: In stall mode, an instruction whose source is the destination of the instruction just ahead holds `imem_addr` for exactly 2 cycles and still gets the correct value.
- R5: In stall mode, a dependency on the instruction two ahead, with none on the one just ahead, holds `imem_addr` for exactly 1 cycle.
- R6: In stall mode, independent instructions run with no stall cycles.
- R7: In bypass mode no stall ever occurs, and dependent instructions at distance 1 and 2 get the correct values.
- R8: In bypass mode, when both the execute-stage and write-back-stage instructions target the requested register, the execute-stage (younger) result wins.
- R9: `dbg_rdata` shows the register addressed by `dbg_addr` one clock later.
- R10: In constant form the bits in the source-B position never cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_mode | input | 1 | 1 selects freeze-and-bubble resolution, 0 selects forwarding |
| imem_addr | output | PC_W | Word address sent to the instruction ROM (registered PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dbg_addr | input | 5 | Register index to observe |
| dbg_rdata | output | 32 | Registered value of the addressed register |

## Verification
The bench counts the cycles in which `imem_addr` fails to advance. A dependency at distance 1 must cost exactly two cycles and one at distance 2 exactly one. A detector that forgot the write-back stage would stall too little and read stale data, and one that forgot the execute stage would read stale data at distance 1. Register 31 is written with a non-zero value and then read straight away, so a forward of the discarded write would show. Two writes to the same register back to back expose a reversed forwarding priority. A constant whose upper bits match an in-flight destination catches a decoder that treats those bits as a register source and stalls for nothing.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int RA_W  = $clog2(NREG);
  localparam int IMM_W = 16;
  localparam logic [RA_W-1:0] ZREG = RA_W'(NREG - 1);

  typedef enum logic [1:0] {
    FN_ADD   = 2'd0,
    FN_SUB   = 2'd1,
    FN_XOR   = 2'd2,
    FN_CMPLE = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic            use_imm;
    alu_fn_e         fn;
    logic [RA_W-1:0] rc;
    logic [RA_W-1:0] ra;
    logic [RA_W-1:0] rb;
    logic [XLEN-1:0] imm;
  } uop_t;

  // add r31 <- r31 + r31: touches nothing and depends on nothing
  localparam logic [31:0] NOP_WORD = 32'h03FF_F800;

  function automatic uop_t decode(input logic [31:0] w);
    uop_t u;
    u.use_imm = w[31];
    u.fn      = alu_fn_e'(w[30:29]);
    u.rc      = w[25:21];
    u.ra      = w[20:16];
    u.rb      = w[15:11];
    u.imm     = {{(XLEN-IMM_W){w[IMM_W-1]}}, w[IMM_W-1:0]};
    return u;
  endfunction
endpackage

// File: rtl/pipe4_regfile.sv
module pipe4_regfile import pipe4_pkg::*; #(
  parameter int W = XLEN,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_rdata
);
  localparam logic [AW-1:0] ZERO_IDX = AW'(N - 1);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we && waddr != ZERO_IDX) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == ZERO_IDX) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == ZERO_IDX) ? '0 : mem[raddr_b];

  always_ff @(posedge clk) begin
    dbg_rdata <= (dbg_addr == ZERO_IDX) ? '0 : mem[dbg_addr];
  end
endmodule

// File: rtl/pipe4_hazard.sv
module pipe4_hazard import pipe4_pkg::*; #(
  parameter int W  = XLEN,
  parameter int AW = RA_W
) (
  input  logic                stall_mode,
  input  logic [1:0][AW-1:0]  src,
  input  logic [1:0]          src_used,
  input  logic [1:0][W-1:0]   reg_val,
  input  logic [AW-1:0]       ex_rc,
  input  logic [W-1:0]        ex_result,
  input  logic [AW-1:0]       wb_rc,
  input  logic [W-1:0]        wb_val,
  output logic [1:0][W-1:0]   opnd,
  output logic                stall
);
  localparam logic [AW-1:0] ZERO_IDX = AW'(ZREG);

  logic [1:0] conflict;

  for (genvar i = 0; i < 2; i++) begin : g_src
    logic live, hit_ex, hit_wb;
    assign live   = src_used[i] && (src[i] != ZERO_IDX);
    assign hit_ex = live && (src[i] == ex_rc);
    assign hit_wb = live && (src[i] == wb_rc);
    assign conflict[i] = hit_ex | hit_wb;

    // younger producer first, then write-back, then the array
    always_comb begin
      if (!stall_mode && hit_ex)      opnd[i] = ex_result;
      else if (!stall_mode && hit_wb) opnd[i] = wb_val;
      else                            opnd[i] = reg_val[i];
    end
  end

  assign stall = stall_mode && (|conflict);
endmodule

// File: rtl/pipe4_alu.sv
module pipe4_alu import pipe4_pkg::*; #(
  parameter int W = XLEN
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_XOR:   y = a ^ b;
      FN_CMPLE: y = W'($signed(a) <= $signed(b));
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/quad_stage_pipe.sv
module quad_stage_pipe import pipe4_pkg::*; #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_mode,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  input  logic [RA_W-1:0] dbg_addr,
  output logic [XLEN-1:0] dbg_rdata
);
  // fetch stage
  logic [PC_W-1:0] pc_q;
  // operand-read stage
  logic [31:0]     rf_ir_q;
  uop_t            rf_u;
  // execute stage
  alu_fn_e         ex_fn;
  logic [RA_W-1:0] ex_rc;
  logic [XLEN-1:0] ex_a, ex_b, ex_y;
  // write-back stage
  logic [RA_W-1:0] wb_rc;
  logic [XLEN-1:0] wb_val;

  logic                 stall;
  logic [1:0][XLEN-1:0] reg_val, opnd;
  logic [1:0][RA_W-1:0] src;
  logic [1:0]           src_used;

  assign rf_u     = decode(rf_ir_q);
  assign src      = {rf_u.rb, rf_u.ra};
  assign src_used = {~rf_u.use_imm, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (!stall) pc_q <= pc_q + 1'b1;
  end
  assign imem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst)         rf_ir_q <= NOP_WORD;
    else if (!stall) rf_ir_q <= imem_data;
  end

  pipe4_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk       (clk),
    .we        (1'b1),
    .waddr     (wb_rc),
    .wdata     (wb_val),
    .raddr_a   (rf_u.ra),
    .rdata_a   (reg_val[0]),
    .raddr_b   (rf_u.rb),
    .rdata_b   (reg_val[1]),
    .dbg_addr  (dbg_addr),
    .dbg_rdata (dbg_rdata)
  );

  pipe4_hazard #(.W(XLEN), .AW(RA_W)) u_hz (
    .stall_mode (stall_mode),
    .src        (src),
    .src_used   (src_used),
    .reg_val    (reg_val),
    .ex_rc      (ex_rc),
    .ex_result  (ex_y),
    .wb_rc      (wb_rc),
    .wb_val     (wb_val),
    .opnd       (opnd),
    .stall      (stall)
  );

  // a held cycle sends a bubble (destination r31) into execute
  always_ff @(posedge clk) begin
    if (rst || stall) begin
      ex_fn <= FN_ADD;
      ex_rc <= ZREG;
      ex_a  <= '0;
      ex_b  <= '0;
    end else begin
      ex_fn <= rf_u.fn;
      ex_rc <= rf_u.rc;
      ex_a  <= opnd[0];
      ex_b  <= rf_u.use_imm ? rf_u.imm : opnd[1];
    end
  end

  pipe4_alu #(.W(XLEN)) u_alu (
    .fn (ex_fn),
    .a  (ex_a),
    .b  (ex_b),
    .y  (ex_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_rc  <= ZREG;
      wb_val <= '0;
    end else begin
      wb_rc  <= ex_rc;
      wb_val <= ex_y;
    end
  end
endmodule

// File: rtl/quad_stage_pipe_chk.sv
module quad_stage_pipe_chk import pipe4_pkg::*; #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            stall_mode,
  input logic [PC_W-1:0] imem_addr,
  input logic [RA_W-1:0] dbg_addr,
  input logic [XLEN-1:0] dbg_rdata,
  input logic            stall,
  input logic [RA_W-1:0] ex_rc
);
  p_pc_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == '0);

  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !stall |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

  p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
    dbg_addr == ZREG |=> dbg_rdata == '0);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(imem_addr));

  p_stall_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> ex_rc == ZREG);

  p_no_stall_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    !stall_mode |-> !stall);
endmodule

bind quad_stage_pipe quad_stage_pipe_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall_mode (stall_mode),
  .imem_addr  (imem_addr),
  .dbg_addr   (dbg_addr),
  .dbg_rdata  (dbg_rdata),
  .stall      (stall),
  .ex_rc      (ex_rc)
);

// File: tb/quad_stage_pipe_bench.sv
`timescale 1ns/1ps
module quad_stage_pipe_bench;
  localparam int PC_W = 8;
  localparam int RUN  = 30;
  localparam logic [31:0] NOPW = 32'h03FF_F800;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            stall_mode = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_data;
  logic [4:0]      dbg_addr = 5'd0;
  logic [31:0]     dbg_rdata;
  logic [31:0]     rom [256];

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign imem_data = rom[imem_addr];

  quad_stage_pipe #(.PC_W(PC_W)) u_quad_stage_pipe (
    .clk(clk), .rst(rst), .stall_mode(stall_mode),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] rr(int fn, int rc, int ra, int rb);
    return {1'b0, 2'(fn), 3'b0, 5'(rc), 5'(ra), 5'(rb), 11'b0};
  endfunction

  function automatic logic [31:0] ri(int fn, int rc, int ra, int imm);
    return {1'b1, 2'(fn), 3'b0, 5'(rc), 5'(ra), 16'(imm)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = NOPW;
  endtask

  task automatic run(input logic mode, output int holds);
    logic [PC_W-1:0] prev;
    stall_mode = mode;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", 32'(imem_addr), 32'd0);
    rst = 1'b0;
    prev = imem_addr;
    holds = 0;
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      if (imem_addr == prev) holds++;
      prev = imem_addr;
    end
    chk("R1 pc advance", 32'(imem_addr), 32'(RUN - holds));
  endtask

  task automatic chk_reg(string req, int r, logic [31:0] exp);
    dbg_addr = 5'(r);
    @(negedge clk);
    chk(req, dbg_rdata, exp);
  endtask

  task automatic wipe_regs();
    int h;
    clear_rom();
    for (int i = 1; i <= 10; i++) rom[i-1] = ri(0, i, 31, 0);
    run(1'b0, h);
  endtask

  task automatic t_ops(input logic mode);
    int h;
    string tag;
    tag = mode ? "R4 stall-mode ops" : "R2/R7 bypass ops";
    wipe_regs();
    clear_rom();
    rom[0]  = ri(0, 1, 31, 5);
    rom[1]  = ri(0, 2, 31, 16'hFFFD);
    rom[2]  = rr(1, 3, 1, 2);
    rom[3]  = rr(2, 4, 1, 2);
    rom[4]  = rr(3, 5, 2, 1);
    rom[5]  = rr(3, 6, 1, 2);
    rom[6]  = ri(3, 7, 1, 5);
    rom[7]  = ri(2, 8, 1, 16'h00FF);
    rom[8]  = rr(0, 31, 1, 1);
    rom[9]  = rr(0, 9, 31, 31);
    rom[10] = ri(1, 10, 3, 1);
    run(mode, h);
    if (!mode) chk("R7 no holds", 32'(h), 32'd0);
    chk_reg({tag, " R2 add const"}, 1, 32'd5);
    chk_reg({tag, " R2 sign ext"}, 2, 32'hFFFF_FFFD);
    chk_reg({tag, " R2 sub"}, 3, 32'd8);
    chk_reg({tag, " R2 xor"}, 4, 32'hFFFF_FFF8);
    chk_reg({tag, " R2 cmple signed true"}, 5, 32'd1);
    chk_reg({tag, " R2 cmple false"}, 6, 32'd0);
    chk_reg({tag, " R2 cmple equal"}, 7, 32'd1);
    chk_reg({tag, " R2 xor const"}, 8, 32'h0000_00FA);
    chk_reg({tag, " R3 r31 not forwarded"}, 9, 32'd0);
    chk_reg({tag, " R3 r31 reads zero"}, 31, 32'd0);
    chk_reg({tag, " sub const"}, 10, 32'd7);
  endtask

  task automatic t_stall_near();
    int h;
    clear_rom();
    rom[0] = ri(0, 1, 31, 7);
    rom[1] = ri(0, 2, 1, 1);
    run(1'b1, h);
    chk("R4 two held cycles", 32'(h), 32'd2);
    chk_reg("R4 value", 2, 32'd8);
  endtask

  task automatic t_stall_far();
    int h;
    clear_rom();
    rom[0] = ri(0, 1, 31, 7);
    rom[1] = ri(0, 5, 31, 1);
    rom[2] = rr(0, 2, 1, 1);
    run(1'b1, h);
    chk("R5 one held cycle", 32'(h), 32'd1);
    chk_reg("R5 value", 2, 32'd14);
  endtask

  task automatic t_stall_free();
    int h;
    clear_rom();
    rom[0] = ri(0, 1, 31, 7);
    rom[1] = ri(0, 2, 31, 16'h0800);
    rom[2] = ri(0, 31, 31, 3);
    rom[3] = rr(0, 4, 31, 31);
    run(1'b1, h);
    chk("R6 R10 R3 no held cycles", 32'(h), 32'd0);
    chk_reg("R10 const value", 2, 32'h0000_0800);
    chk_reg("R3 zero source", 4, 32'd0);
  endtask

  task automatic t_priority();
    int h;
    clear_rom();
    rom[0] = ri(0, 1, 31, 1);
    rom[1] = ri(0, 1, 31, 2);
    rom[2] = rr(0, 2, 1, 31);
    rom[3] = ri(0, 5, 31, 9);
    rom[4] = ri(0, 7, 31, 0);
    rom[5] = ri(0, 6, 5, 1);
    run(1'b0, h);
    chk("R7 no holds", 32'(h), 32'd0);
    chk_reg("R8 younger wins", 2, 32'd2);
    chk_reg("R7 distance 2 forward", 6, 32'd10);
  endtask

  task automatic t_debug();
    dbg_addr = 5'd2;
    @(negedge clk);
    dbg_addr = 5'd6;
    #1;
    chk("R9 old value before edge", dbg_rdata, 32'd2);
    @(negedge clk);
    chk("R9 new value after edge", dbg_rdata, 32'd10);
  endtask

  initial begin
    clear_rom();
    t_ops(1'b0);
    t_ops(1'b1);
    t_stall_near();
    t_stall_far();
    t_stall_free();
    t_priority();
    t_debug();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule